// File: doc/BRIEF.md
# Oversampled Phase-Selection Bit Recovery

This block turns a triple-oversampled serial stream back into data bits without steering any clock. Each internal clock cycle it accepts one word of 24 samples covering eight bit periods, three equally spaced samples per bit. It locates bit boundaries by looking for value changes between neighbouring samples. It then keeps a phase pointer that names which of the three sample slots is taken for every bit. The pointer is steered to the slot farthest from where the boundaries fall. The raw samples travel through a delay line as long as the decision logic, so each decision is applied to the same word that produced it.

When the pointer wraps around the three slots, a cycle yields seven or nine bits instead of eight. The recovered bits leave as a variable-length group with a count. A regrouping register then packs them into aligned 8-bit words with a strobe, so downstream logic sees a plain byte stream.

Top module: `osr_recover`

## Requirements
- R1: Bit j of `smp_i` is the j-th sample in time (bit 0 earliest). Consecutive triples of samples cover one data bit.
- R2: While `rst_n` is low, `rec_vld_o`, `word_vld_o` and `word_o` are 0. The phase pointer starts at the middle slot (1), and the remembered last sample is 0.
- R3: `rec_vld_o` is high exactly three clock cycles after a cycle in which `smp_vld_i` was high, and never otherwise. A cycle with `smp_vld_i` low changes neither the pointer nor the remembered last sample.
- R4: Boundary detection compares every sample with the one before it. For sample 0 that is sample 23 of the previous accepted word, so a boundary on the word seam is still seen.
- R5: Boundaries are tallied by their slot (sample index mod 3). If one slot has strictly more boundaries than each of the others, the target is the next slot (mod 3). The pointer then moves one step towards the target. Ties, and words with no boundary, leave the pointer unchanged.
- R6: A word whose decision does not wrap yields 8 bits: the samples at slot p, p+3, ..., p+21 under the new pointer p, placed LSB-first in `rec_bits_o`, with `rec_cnt_o` = 8.
- R7: A move from slot 2 to slot 0 yields 7 bits: sample 0 is dropped and samples 3..21 are kept. A move from slot 0 to slot 2 yields 9 bits: the last sample of the previous word first, then samples 2..23. Unused upper bits of `rec_bits_o` are 0.
- R8: The regrouping stage emits `word_o` with `word_vld_o` whenever 8 or more bits are held, LSB earliest. No bit is lost or duplicated, and at most 15 bits stay pending.
- R9: Random run-length-limited data (runs of at most 5) is recovered without error while the sampling phase wanders back and forth by one sample at a time.
- R10: A repeating single-one-in-eight pattern is recovered without error while its phase walks steadily across all sample positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 24 | Oversampled word, bit 0 earliest |
| smp_vld_i | input | 1 | `smp_i` carries a new word this cycle |
| rec_bits_o | output | 9 | Recovered bits, LSB earliest |
| rec_cnt_o | output | 4 | Number of valid bits in `rec_bits_o` (7, 8 or 9) |
| rec_vld_o | output | 1 | `rec_bits_o`/`rec_cnt_o` valid |
| word_o | output | 8 | Regrouped byte, bit 0 earliest |
| word_vld_o | output | 1 | `word_o` valid |

## Verification
Several behaviours hold on every clock and are checked as properties: the fixed three-cycle valid latency, a legal pointer value, a held pointer after a word with no boundaries, and a count that always lies between seven and nine. The properties also check that a nine- or seven-bit group appears only together with the matching pointer wrap, and that the regrouping register never overflows. Whether the chosen samples are the right bits, and whether the seam handling and wrap handling keep the byte stream free of gaps and repeats, can only be shown by the bench. It compares every emitted byte with the source bit stream, first under phase wander with random data and then under a steady walk of a sparse pulse pattern.

// File: rtl/osr_pkg.sv
package osr_pkg;
  parameter int unsigned OVS  = 3;               // samples per bit
  parameter int unsigned BITS = 8;               // bits per clock cycle
  parameter int unsigned SMP  = OVS * BITS;      // samples per word
  parameter int unsigned CW   = $clog2(BITS + 1);      // per-slot tally width
  parameter int unsigned PW   = $clog2(OVS);           // pointer width
  parameter int unsigned NW   = $clog2(BITS + 2);      // group count width
  parameter int unsigned ACC  = 4 * BITS;              // regroup storage
  parameter int unsigned FW   = $clog2(ACC + 1);       // regroup fill width

  typedef logic [PW-1:0] slot_t;
  typedef logic [OVS-1:0][CW-1:0] tally_t;
endpackage

// File: rtl/osr_edge_bin.sv
module osr_edge_bin
  import osr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SMP-1:0] smp_i,
  input  logic           smp_vld_i,
  output logic [SMP:0]   ext_o,
  output tally_t         tally_o,
  output logic           vld_o
);
  logic         seam_q;
  logic [SMP:0] ext1_q;
  logic         v1_q;
  tally_t       tally_d;

  // R4: boundary at sample j sits between ext1_q[j] and ext1_q[j+1]
  always_comb begin
    tally_d = '0;
    for (int j = 0; j < SMP; j++) begin
      if (ext1_q[j+1] != ext1_q[j])
        tally_d[j % OVS] = tally_d[j % OVS] + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seam_q  <= 1'b0;
      ext1_q  <= '0;
      v1_q    <= 1'b0;
      ext_o   <= '0;
      tally_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      v1_q  <= smp_vld_i;
      vld_o <= v1_q;
      if (smp_vld_i) begin
        ext1_q <= {smp_i, seam_q};
        seam_q <= smp_i[SMP-1];
      end
      if (v1_q) begin
        ext_o   <= ext1_q;
        tally_o <= tally_d;
      end
    end
  end

  // R3: an idle cycle leaves the remembered seam sample untouched
  assert_seam_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> $stable(seam_q));
endmodule

// File: rtl/osr_phase_sel.sv
module osr_phase_sel
  import osr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [SMP:0]  ext_i,
  input  tally_t        tally_i,
  output logic [BITS:0] bits_o,
  output logic [NW-1:0] num_o,
  output logic          vld_o
);
  localparam slot_t MID  = slot_t'(OVS / 2);
  localparam slot_t LAST = slot_t'(OVS - 1);

  slot_t           ptr_q, nptr, win, tgt, up, dn;
  logic            win_ok, beats, fwd, bwd;
  logic [BITS-1:0] sel;
  logic [BITS:0]   bits_d;
  logic [NW-1:0]   num_d;

  // R5: a strict winner slot picks the target, otherwise hold
  always_comb begin
    win_ok = 1'b0;
    win    = '0;
    beats  = 1'b0;
    for (int i = 0; i < OVS; i++) begin
      beats = 1'b1;
      for (int m = 0; m < OVS; m++) begin
        if (m != i && tally_i[m] >= tally_i[i]) beats = 1'b0;
      end
      if (beats) begin
        win_ok = 1'b1;
        win    = slot_t'(i);
      end
    end
  end

  always_comb begin
    tgt  = (win == LAST) ? slot_t'(0) : win + slot_t'(1);
    up   = (ptr_q == LAST) ? slot_t'(0) : ptr_q + slot_t'(1);
    dn   = (ptr_q == '0) ? LAST : ptr_q - slot_t'(1);
    nptr = ptr_q;
    if (win_ok) begin
      if (tgt == up)      nptr = up;
      else if (tgt == dn) nptr = dn;
    end
    fwd = (ptr_q == LAST) && (nptr == '0);
    bwd = (ptr_q == '0) && (nptr == LAST);
  end

  // R6/R7: selection under the new pointer, with wrap adjustment
  always_comb begin
    for (int k = 0; k < BITS; k++) sel[k] = ext_i[int'(nptr) + OVS * k + 1];
    bits_d = '0;
    if (bwd) begin
      bits_d = {sel, ext_i[0]};
      num_d  = NW'(BITS + 1);
    end else if (fwd) begin
      bits_d[BITS-2:0] = sel[BITS-1:1];
      num_d  = NW'(BITS - 1);
    end else begin
      bits_d[BITS-1:0] = sel;
      num_d  = NW'(BITS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= MID;
      bits_o <= '0;
      num_o  <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        ptr_q  <= nptr;
        bits_o <= bits_d;
        num_o  <= num_d;
      end
    end
  end

  assert_ptr_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
  assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && tally_i == '0) |=> ptr_q == $past(ptr_q));
  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (num_o >= NW'(BITS - 1) && num_o <= NW'(BITS + 1)));
  assert_nine_on_back_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && num_o == NW'(BITS + 1)) |-> (ptr_q == LAST && $past(ptr_q) == '0));
  assert_seven_on_fwd_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && num_o == NW'(BITS - 1)) |-> (ptr_q == '0 && $past(ptr_q) == LAST));
endmodule

// File: rtl/osr_regroup.sv
module osr_regroup
  import osr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_i,
  input  logic [BITS:0]   bits_i,
  input  logic [NW-1:0]   num_i,
  output logic [BITS-1:0] word_o,
  output logic            word_vld_o
);
  logic [ACC-1:0] acc_q, acc_d, merged;
  logic [FW-1:0]  fill_q, fill_d, total;
  logic           emit;

  always_comb begin
    merged = acc_q;
    total  = fill_q;
    if (vld_i) begin
      merged = acc_q | ({{(ACC-BITS-1){1'b0}}, bits_i} << fill_q);
      total  = fill_q + FW'(num_i);
    end
    emit   = total >= FW'(BITS);
    acc_d  = emit ? (merged >> BITS) : merged;
    fill_d = emit ? total - FW'(BITS) : total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      fill_q     <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      acc_q      <= acc_d;
      fill_q     <= fill_d;
      word_vld_o <= emit;
      if (emit) word_o <= merged[BITS-1:0];
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (int'(fill_q) + BITS + 1 <= ACC));
  assert_pending_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q < FW'(2 * BITS));
endmodule

// File: rtl/osr_recover.sv
module osr_recover
  import osr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SMP-1:0]  smp_i,
  input  logic            smp_vld_i,
  output logic [BITS:0]   rec_bits_o,
  output logic [NW-1:0]   rec_cnt_o,
  output logic            rec_vld_o,
  output logic [BITS-1:0] word_o,
  output logic            word_vld_o
);
  logic [SMP:0] ext;
  tally_t       tally;
  logic         tvld;

  osr_edge_bin u_bin (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .ext_o(ext), .tally_o(tally), .vld_o(tvld)
  );

  osr_phase_sel u_sel (
    .clk(clk), .rst_n(rst_n), .vld_i(tvld), .ext_i(ext), .tally_i(tally),
    .bits_o(rec_bits_o), .num_o(rec_cnt_o), .vld_o(rec_vld_o)
  );

  osr_regroup u_grp (
    .clk(clk), .rst_n(rst_n), .vld_i(rec_vld_o), .bits_i(rec_bits_o),
    .num_i(rec_cnt_o), .word_o(word_o), .word_vld_o(word_vld_o)
  );

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld_o == $past(smp_vld_i, 3));
endmodule

// File: tb/sim_osr_recover.sv
`timescale 1ns/1ps
module sim_osr_recover;
  localparam int NB = 14600;
  localparam int NCYC = 1800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] smp_i = '0;
  logic        smp_vld_i = 1'b0;
  logic [8:0]  rec_bits_o;
  logic [3:0]  rec_cnt_o;
  logic        rec_vld_o;
  logic [7:0]  word_o;
  logic        word_vld_o;

  osr_recover u0 (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .rec_bits_o(rec_bits_o), .rec_cnt_o(rec_cnt_o), .rec_vld_o(rec_vld_o),
    .word_o(word_o), .word_vld_o(word_vld_o)
  );

  always #2.5 clk = ~clk;

  bit   ref_b [NB];
  int   checks = 0, fails = 0;
  int   widx = 0, bits_out = 0, seen7 = 0, seen9 = 0;
  logic [2:0] vh = '0;
  bit   mon_on = 0, done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: one data bit spans three consecutive samples, shifted by off
  function automatic logic [23:0] make_word(input int s, input int off);
    logic [23:0] w;
    for (int j = 0; j < 24; j++) w[j] = ref_b[(s + j - off) / 3];
    return w;
  endfunction

  function automatic logic [7:0] ref_byte(input int idx);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = ref_b[idx * 8 + i];
    return b;
  endfunction

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      check(rec_vld_o == vh[2], "R3 valid latency", rec_vld_o, vh[2]);
      if (rec_vld_o) begin
        check(rec_cnt_o >= 7 && rec_cnt_o <= 9, "R6/R7 count range", rec_cnt_o, 8);
        if (rec_cnt_o == 7) seen7++;
        if (rec_cnt_o == 9) seen9++;
        bits_out += int'(rec_cnt_o);
      end
      if (word_vld_o) begin
        if (widx < 1025)
          check(word_o == ref_byte(widx), "R9 R4 R5 R8 byte", word_o, ref_byte(widx));
        else
          check(word_o == ref_byte(widx), "R10 R8 walking byte", word_o, ref_byte(widx));
        widx++;
      end
      vh <= {vh[1:0], smp_vld_i};
    end
  end

  initial begin
    int run;
    bit last;
    int s, off, dir;
    void'($urandom(32'h5eed_0a17));
    run = 0; last = 0;
    for (int n = 0; n < NB; n++) begin
      if (n < 8200) begin
        bit b;
        b = bit'($urandom_range(0, 1));
        if (run >= 5 && b == last) b = ~last;   // run limit of five
        run = (n > 0 && b == last) ? run + 1 : 1;
        ref_b[n] = b;
        last = b;
      end else begin
        ref_b[n] = (n % 8 == 0);
      end
    end

    // R2: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rec_vld_o == 0, "R2 reset rec_vld", rec_vld_o, 0);
    check(word_vld_o == 0, "R2 reset word_vld", word_vld_o, 0);
    check(word_o == 0, "R2 reset word", word_o, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_on = 1;

    s = 0; off = 0; dir = 1;
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk); #1;
      if (c < 1000) begin
        if (c > 0 && c % 25 == 0) begin
          off += dir;
          if (off == 6) dir = -1;
          if (off == 0) dir = 1;
        end
      end else if (c % 20 == 0) begin
        off++;
      end
      // first cycles always valid; later an occasional idle cycle (R3)
      if (c > 4 && $urandom_range(0, 15) == 0) begin
        smp_vld_i = 1'b0;
        smp_i = $urandom();                 // ignored content
      end else begin
        smp_vld_i = 1'b1;
        smp_i = make_word(s, off);
        s += 24;
      end
    end
    @(posedge clk); #1;
    smp_vld_i = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    mon_on = 0;
    check(seen7 > 0, "R7 seven-bit group seen", seen7, 1);
    check(seen9 > 0, "R7 nine-bit group seen", seen9, 1);
    check(bits_out - widx * 8 >= 0 && bits_out - widx * 8 < 16,
          "R8 pending bits", bits_out - widx * 8, 0);
    check(widx > 1500, "R8 byte count", widx, 1500);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule